// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of an asynchronous fast-page-mode DRAM. It brings the memory out of power-up before any normal traffic reaches it. After reset it waits a start-up interval measured in system clocks. It then issues a run of dummy refresh cycles on the active-low row strobe, column strobe and write-enable lines. Once the last of these cycles has ended and every strobe is back high, a ready flag rises. Until that point, client requests are refused.

A parameter picks the kind of dummy cycle. In RAS-only mode the column strobe stays high and an internal row counter places an incrementing row address on the address bus for each cycle. In CAS-before-RAS mode the column strobe falls first and the row strobe follows, while write-enable stays high so that no test mode is entered. A second parameter declares that the memory's own refresh counter will be used; this forces CAS-before-RAS whatever the style parameter says. The wait length, cycle count and pulse widths are all parameters in clocks, with defaults derived from the clock period. The wait and the cycle count are never allowed below their safe minimums.

Top module: `dramInitSeq`

## Requirements
- R1: While reset is high and in the cycle after it, rasN, casN and weN are 1, ready and reqGrant are 0, and rowAddr is 0.
- R2: After reset, rasN and casN stay high for S clocks, where S is the larger of STARTUP_CYC and ceil(200000 ns / CLK_PERIOD_NS). The default of 10 ns gives S = 20000.
- R3: In RAS-only mode each dummy cycle is rasN low for RAS_CYC clocks with casN high, followed by PRE_CYC clocks with both strobes high.
- R4: In CAS-before-RAS mode each dummy cycle is casN low alone for LEAD_CYC clocks, then both strobes low for RAS_CYC clocks, then PRE_CYC clocks with both high. rasN never falls unless casN was already low in the clock before.
- R5: weN is 1 in every cycle.
- R6: ready rises in the clock after the last precharge clock of the last dummy cycle. It stays 1 until reset, and rasN and casN are 1 whenever ready is 1.
- R7: reqGrant equals reqValid AND ready, so no request is accepted while ready is 0.
- R8: In RAS-only mode rowAddr holds k (counting from 0) during the whole low pulse of rasN in dummy cycle k.
- R9: The number of dummy cycles is the larger of NUM_CYCLES and 8.
- R10: With USE_INT_REFRESH = 1, the cycles follow the R4 waveform even when REFRESH_STYLE selects RAS-only (REFRESH_STYLE: 0 = RAS-only, 1 = CAS-before-RAS).
- R11: Raising reset at any point returns all outputs to the R1 state and restarts the sequence from the beginning of the R2 wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| reqValid | input | 1 | Client request presented |
| reqGrant | output | 1 | Request accepted (only once ready) |
| ready | output | 1 | Initialization complete, memory usable |
| rasN | output | 1 | Active-low row address strobe |
| casN | output | 1 | Active-low column address strobe |
| weN | output | 1 | Active-low write enable, held high |
| rowAddr | output | ROW_W | Row address for RAS-only refresh cycles |

## Verification
The bound checker examines every clock. It checks that the column strobe leads the row strobe's falling edge in CAS-before-RAS mode and that the column strobe stays high in RAS-only mode. It also checks that write-enable never drops, that ready is sticky and only seen with both strobes high, that grants need ready, and that the row address is steady through each row pulse. What no per-cycle property can show is the exact length of the start-up wait, the clamping of the wait and the cycle count to their minimums, the forcing of CAS-before-RAS by the internal-counter option, and the restart after a mid-sequence reset. The bench covers these by comparing both instances against a behavioural timeline on every clock.

// File: rtl/dramInitPkg.sv
package dramInitPkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_LEAD,
    ST_RAS,
    ST_PRE,
    ST_DONE
  } phase_e;

  typedef struct packed {
    logic rasOn;
    logic casOn;
    logic rowStep;
    logic done;
  } strobe_t;
endpackage

// File: rtl/dramInitCtrl.sv
module dramInitCtrl
  import dramInitPkg::*;
#(
  parameter int STARTUP_CYC = 20000,
  parameter int LEAD_CYC    = 2,
  parameter int RAS_CYC     = 6,
  parameter int PRE_CYC     = 4,
  parameter int INIT_CYC    = 8,
  parameter bit CBR         = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobes
);
  localparam int MAX_A  = (STARTUP_CYC > RAS_CYC) ? STARTUP_CYC : RAS_CYC;
  localparam int MAX_B  = (LEAD_CYC > PRE_CYC) ? LEAD_CYC : PRE_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_C + 1);
  localparam int CYC_W  = $clog2(INIT_CYC + 1);
  localparam phase_e FIRST_PH = CBR ? ST_LEAD : ST_RAS;

  phase_e phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic [CYC_W-1:0] cycIdx, cycIdxNext;

  // length of the current phase, minus one
  logic [CNT_W-1:0] phaseLast;
  always_comb begin
    unique case (phase)
      ST_WAIT: phaseLast = CNT_W'(STARTUP_CYC - 1);
      ST_LEAD: phaseLast = CNT_W'(LEAD_CYC - 1);
      ST_RAS:  phaseLast = CNT_W'(RAS_CYC - 1);
      ST_PRE:  phaseLast = CNT_W'(PRE_CYC - 1);
      default: phaseLast = '0;
    endcase
  end

  wire phaseEnd = (cnt == phaseLast);

  always_comb begin
    phaseNext  = phase;
    cntNext    = cnt + 1'b1;
    cycIdxNext = cycIdx;
    if (phase == ST_DONE) begin
      cntNext = cnt;
    end else if (phaseEnd) begin
      cntNext = '0;
      unique case (phase)
        ST_WAIT: phaseNext = FIRST_PH;
        ST_LEAD: phaseNext = ST_RAS;
        ST_RAS:  phaseNext = ST_PRE;
        ST_PRE: begin
          if (cycIdx == CYC_W'(INIT_CYC - 1)) begin
            phaseNext = ST_DONE;
          end else begin
            phaseNext  = FIRST_PH;
            cycIdxNext = cycIdx + 1'b1;
          end
        end
        default: phaseNext = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= ST_WAIT;
      cnt    <= '0;
      cycIdx <= '0;
    end else begin
      phase  <= phaseNext;
      cnt    <= cntNext;
      cycIdx <= cycIdxNext;
    end
  end

  always_comb begin
    strobes.rasOn   = (phase == ST_RAS);
    strobes.casOn   = (phase == ST_LEAD) || (CBR && phase == ST_RAS);
    strobes.rowStep = (phase == ST_PRE) && phaseEnd;
    strobes.done    = (phase == ST_DONE);
  end
endmodule

// File: rtl/dramInitPath.sv
module dramInitPath
  import dramInitPkg::*;
#(
  parameter int ROW_W = 12,
  parameter bit CBR   = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobes,
  input  logic             reqValid,
  output logic             reqGrant,
  output logic             ready,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [ROW_W-1:0] rowAddr
);
  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rasN  <= 1'b1;
      casN  <= 1'b1;
      weN   <= 1'b1;
      ready <= 1'b0;
    end else begin
      rasN  <= ~strobes.rasOn;
      casN  <= ~strobes.casOn;
      weN   <= 1'b1;
      ready <= strobes.done;
    end
  end

  generate
    if (CBR) begin : gCbrRow
      always_ff @(posedge clk) begin
        rowCnt <= '0;
      end
    end else begin : gRorRow
      always_ff @(posedge clk) begin
        if (rst)                  rowCnt <= '0;
        else if (strobes.rowStep) rowCnt <= rowCnt + 1'b1;
      end
    end
  endgenerate

  assign rowAddr  = rowCnt;
  assign reqGrant = reqValid & ready;
endmodule

// File: rtl/dramInitSeq.sv
module dramInitSeq
  import dramInitPkg::*;
#(
  parameter int CLK_PERIOD_NS   = 10,
  parameter int STARTUP_CYC     = (200000 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS,
  parameter int NUM_CYCLES      = 8,
  parameter int LEAD_CYC        = (20 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS,
  parameter int RAS_CYC         = (60 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS,
  parameter int PRE_CYC         = (40 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS,
  parameter int REFRESH_STYLE   = 1,
  parameter bit USE_INT_REFRESH = 1'b0,
  parameter int ROW_W           = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  output logic             reqGrant,
  output logic             ready,
  output logic             rasN,
  output logic             casN,
  output logic             weN,
  output logic [ROW_W-1:0] rowAddr
);
  localparam int MIN_WAIT = (200000 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int WAIT_EFF = (STARTUP_CYC > MIN_WAIT) ? STARTUP_CYC : MIN_WAIT;
  localparam int INIT_EFF = (NUM_CYCLES > 8) ? NUM_CYCLES : 8;
  localparam int LEAD_EFF = (LEAD_CYC > 1) ? LEAD_CYC : 1;
  localparam int RAS_EFF  = (RAS_CYC > 1) ? RAS_CYC : 1;
  localparam int PRE_EFF  = (PRE_CYC > 1) ? PRE_CYC : 1;
  localparam bit CBR_EFF  = USE_INT_REFRESH || (REFRESH_STYLE != 0);

  strobe_t strobes;
  logic    cbrSel;
  assign cbrSel = CBR_EFF;

  dramInitCtrl #(
    .STARTUP_CYC(WAIT_EFF), .LEAD_CYC(LEAD_EFF), .RAS_CYC(RAS_EFF),
    .PRE_CYC(PRE_EFF), .INIT_CYC(INIT_EFF), .CBR(CBR_EFF)
  ) uCtrl (
    .clk(clk), .rst(rst), .strobes(strobes)
  );

  dramInitPath #(.ROW_W(ROW_W), .CBR(CBR_EFF)) uPath (
    .clk(clk), .rst(rst), .strobes(strobes), .reqValid(reqValid),
    .reqGrant(reqGrant), .ready(ready), .rasN(rasN), .casN(casN),
    .weN(weN), .rowAddr(rowAddr)
  );
endmodule

// File: rtl/dramInitChk.sv
module dramInitChk #(
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cbrSel,
  input logic             reqGrant,
  input logic             ready,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic [ROW_W-1:0] rowAddr
);
  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    (cbrSel && $fell(rasN)) |-> (!casN && $past(!casN)));

  a_r3_rasonly_cas_high: assert property (@(posedge clk) disable iff (rst)
    !cbrSel |-> casN);

  a_r5_we_high: assert property (@(posedge clk) disable iff (rst) weN);

  a_r6_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  a_r6_ready_idle_strobes: assert property (@(posedge clk) disable iff (rst)
    ready |-> (rasN && casN));

  a_r7_grant_needs_ready: assert property (@(posedge clk) disable iff (rst)
    reqGrant |-> ready);

  a_r8_row_steady: assert property (@(posedge clk) disable iff (rst)
    (!rasN && $past(!rasN)) |-> $stable(rowAddr));
endmodule

bind dramInitSeq dramInitChk #(.ROW_W(ROW_W)) uChk (
  .clk(clk), .rst(rst), .cbrSel(cbrSel), .reqGrant(reqGrant), .ready(ready),
  .rasN(rasN), .casN(casN), .weN(weN), .rowAddr(rowAddr)
);

// File: tb/test_dramInitSeq.sv
module test_dramInitSeq;
  localparam int ROW_W = 12;
  localparam int S     = 20000;  // 200 us at 10 ns
  localparam int N     = 8;
  localparam int LEAD  = 2;
  localparam int RASW  = 6;
  localparam int PRE   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  always #5 clk = ~clk;

  // instance A: RAS-only style requested, internal counter forces CBR (R10)
  logic gA, rdyA, rasA, casA, weA;
  logic [ROW_W-1:0] rowA;
  dramInitSeq #(.REFRESH_STYLE(0), .USE_INT_REFRESH(1'b1)) i_dramInitSeq (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqGrant(gA), .ready(rdyA),
    .rasN(rasA), .casN(casA), .weN(weA), .rowAddr(rowA));

  // instance B: RAS-only, values below minimum get clamped (R2, R9)
  logic gB, rdyB, rasB, casB, weB;
  logic [ROW_W-1:0] rowB;
  dramInitSeq #(.REFRESH_STYLE(0), .STARTUP_CYC(100), .NUM_CYCLES(3))
    i_dramInitSeqRasOnly (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqGrant(gB), .ready(rdyB),
    .rasN(rasB), .casN(casB), .weN(weB), .rowAddr(rowB));

  int tests = 0;
  int fails = 0;
  int n = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at step %0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  // behavioural timeline: n = clocks since reset released (0 = reset)
  task automatic expect_at(input int k, input bit cbr, output bit eRas,
                           output bit eCas, output bit eRdy, output int eRow);
    int per, m, c, p;
    eRas = 1; eCas = 1; eRdy = 0; eRow = -1;
    per = (cbr ? LEAD : 0) + RASW + PRE;
    if (k > S) begin
      m = k - S - 1;
      if (m >= N * per) eRdy = 1;
      else begin
        c = m / per;
        p = m % per;
        if (cbr) begin
          if (p < LEAD) eCas = 0;
          else if (p < LEAD + RASW) begin eCas = 0; eRas = 0; end
        end else if (p < RASW) begin
          eRas = 0;
          eRow = c;
        end
      end
    end
  endtask

  task automatic compare_all();
    bit r, c, y;
    int w;
    expect_at(n, 1'b1, r, c, y, w);
    chk("R4/R10 rasN A", rasA, r);
    chk("R4/R10 casN A", casA, c);
    chk("R6/R9 ready A", rdyA, y);
    chk("R5 weN A", weA, 1);
    chk("R7 grant A", gA, reqValid & y);
    expect_at(n, 1'b0, r, c, y, w);
    chk("R2/R3 rasN B", rasB, r);
    chk("R3 casN B", casB, c);
    chk("R6/R9 ready B", rdyB, y);
    chk("R5 weN B", weB, 1);
    chk("R7 grant B", gB, reqValid & y);
    if (w >= 0) chk("R8 rowAddr B", rowB, w);
  endtask

  task automatic step(input bit r);
    rst = r;
    @(negedge clk);
    n = r ? 0 : n + 1;
    compare_all();
  endtask

  initial begin
    @(negedge clk);
    step(1'b1);
    step(1'b1);
    // R1: reset state
    chk("R1 rasN", rasA & rasB, 1);
    chk("R1 casN", casA & casB, 1);
    chk("R1 ready", rdyA | rdyB, 0);
    chk("R1 rowAddr", rowB, 0);
    reqValid = 1'b1;
    for (int i = 0; i < S + 15; i++) step(1'b0);
    // R11: reset in the middle of a refresh cycle
    step(1'b1);
    step(1'b1);
    chk("R11 rasN after reset", rasA & rasB, 1);
    chk("R11 casN after reset", casA & casB, 1);
    chk("R11 rowAddr after reset", rowB, 0);
    for (int i = 0; i < S + N * (LEAD + RASW + PRE) + 20; i++) step(1'b0);
    chk("R6 ready A final", rdyA, 1);
    chk("R6 ready B final", rdyB, 1);
    chk("R8 row count B final", rowB, N);
    reqValid = 1'b0;
    step(1'b0);
    chk("R7 no grant without request", gA | gB, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (120000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule